// File: doc/BRIEF.md
# Two-Channel Interleaved Recursive Multiply-Add Filter

This block evaluates two independent first-order recursions of lag two on one shared, pipelined multiply-add datapath. The recursions are x(n) = a·x(n-2) + u(n) and y(n) = b·y(n-2) + v(n). The samples of the two channels share one input port and take alternate clock cycles. The first sample after reset belongs to channel x, and every cycle carries a new sample. The feedback path holds four registers instead of two, so each channel sees its own lag-two history, while the other channel fills the slots in between.

The multiplier is split into two registered stages. The first stage forms two partial products, one from the low half of the feedback operand and one from the high half. The second stage recombines them and truncates the result. One register follows the adder, and one register holds the fed-back result, so the four loop delays sit between the pipeline stages rather than in one place. The coefficient is chosen by slot position. Each input carries a channel tag, and a tag that does not match its slot is flagged alongside the matching output. The datapath is unchanged by a wrong tag.

Top module: `ilv_mac_filter`

## Requirements
- R1: While rst_n is low, out_valid, out_data and out_tag_err are all 0.
- R2: The result for a sample sampled at clock edge k appears on out_data just after edge k+1.
- R3: Slots 0, 2, 4, … after reset belong to channel x. The result of such a slot t is in(t) + coef_a·res(t-4), where res is zero for any slot before the first.
- R4: Slots 1, 3, 5, … belong to channel y and use coef_b and res(t-4) in the same way. The two channels never mix.
- R5: Reset clears every loop register, so the first four results after reset equal their inputs.
- R6: Data and coefficients are 24-bit two's complement with 12 fractional bits. Each product is floored (shifted right by 12, rounding toward minus infinity) and kept to its low 24 bits, and the sum wraps modulo 2^24.
- R7: out_chan is 0 for a channel-x result and 1 for a channel-y result, and it alternates on every valid output, starting at 0.
- R8: out_tag_err is 1 with a result exactly when that sample's in_tag differed from its slot's channel (0 for x, 1 for y).
- R9: A wrong in_tag does not change out_data, because the coefficient and history follow slot position.
- R10: out_valid is 0 until the first result appears and then stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_a | input | 24 | Channel-x coefficient, signed Q12 |
| coef_b | input | 24 | Channel-y coefficient, signed Q12 |
| in_data | input | 24 | Interleaved input sample, signed Q12 |
| in_tag | input | 1 | Channel tag claimed by the sample (0 = x, 1 = y) |
| out_data | output | 24 | Interleaved result, signed Q12 |
| out_chan | output | 1 | Channel of the current result (0 = x, 1 = y) |
| out_valid | output | 1 | Result present |
| out_tag_err | output | 1 | Tag of this result's sample did not match its slot |

## Verification
A directed run opens with four distinct values, which shows that the history starts cleared and separates the four loop positions. A long run then uses different coefficients on the two channels, so any mixing of histories or coefficients between the channels shows up at once. Full-scale inputs with a unity coefficient force wraparound. Coefficients of plus and minus one LSB on mixed-sign data separate floor truncation from rounding toward zero. A run with randomly corrupted tags must raise the error flag on exactly those slots while the data still follows the clean reference.

// File: rtl/ilv_mac_pkg.sv
package ilv_mac_pkg;

  // Channel occupying a time slot; slot parity after reset picks it.
  typedef enum logic {
    CH_X = 1'b0,
    CH_Y = 1'b1
  } chan_e;

endpackage

// File: rtl/ilv_slot_seq.sv
// Slot sequencer: tracks slot parity, carries it down the pipeline,
// checks the incoming channel tag and produces the output valid.
module ilv_slot_seq
  import ilv_mac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_tag,
  output chan_e out_ch,
  output chan_e fb_ch,
  output logic  out_valid,
  output logic  out_tag_err
);

  chan_e phase_q, phase_d;
  chan_e in_ch_q, out_ch_q, fb_ch_q;
  logic  live_q, valid_q;
  logic  bad_q, bad_d, err_q;

  always_comb begin
    phase_d = chan_e'(~phase_q);
    bad_d   = (in_tag != 1'(phase_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= CH_X;
      in_ch_q  <= CH_X;
      out_ch_q <= CH_X;
      fb_ch_q  <= CH_X;
      live_q   <= 1'b0;
      valid_q  <= 1'b0;
      bad_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      in_ch_q  <= phase_q;
      out_ch_q <= in_ch_q;
      fb_ch_q  <= out_ch_q;
      live_q   <= 1'b1;
      valid_q  <= live_q;
      bad_q    <= bad_d;
      err_q    <= bad_q;
    end
  end

  assign out_ch      = out_ch_q;
  assign fb_ch       = fb_ch_q;
  assign out_valid   = valid_q;
  assign out_tag_err = err_q;

  // R10: once results flow they keep flowing
  a_r10_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid);

  // R7: channel alternates on every valid output
  a_r7_chan_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> (out_ch_q != $past(out_ch_q)));

  // R8: flag reflects the tag presented two edges earlier against its slot
  a_r8_err_tracks_tag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_tag_err == ($past(in_tag, 2) != 1'(out_ch_q))));

  // R8: no flag without a result
  a_r8_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_tag_err |-> out_valid);

endmodule

// File: rtl/ilv_split_mul.sv
// Two-stage fractional multiplier: stage one forms partial products on
// the low and high halves of the operand, stage two recombines, floors
// by FRAC_W and keeps DATA_W bits.
module ilv_split_mul #(
  parameter int DATA_W = 24,
  parameter int FRAC_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [DATA_W-1:0] coef,
  input  logic signed [DATA_W-1:0] opnd,
  output logic signed [DATA_W-1:0] prod
);

  localparam int LO_W   = DATA_W / 2;
  localparam int HI_W   = DATA_W - LO_W;
  localparam int PLO_W  = DATA_W + LO_W + 1;
  localparam int PHI_W  = DATA_W + HI_W;
  localparam int FULL_W = 2 * DATA_W;

  logic signed [LO_W:0]       lo_ext;
  logic signed [HI_W-1:0]     hi_part;
  logic signed [PLO_W-1:0]    pp_lo_d, pp_lo_q;
  logic signed [PHI_W-1:0]    pp_hi_d, pp_hi_q;
  logic signed [FULL_W-1:0]   full_d;
  logic signed [DATA_W-1:0]   prod_d, prod_q;
  logic                       unused_full_bits;

  // stage one: partial products
  always_comb begin
    lo_ext  = $signed({1'b0, opnd[LO_W-1:0]});
    hi_part = opnd[DATA_W-1:LO_W];
    pp_lo_d = coef * lo_ext;
    pp_hi_d = coef * hi_part;
  end

  // stage two: recombine, floor by FRAC_W, wrap to DATA_W
  always_comb begin
    full_d = (FULL_W'(pp_hi_q) <<< LO_W) + FULL_W'(pp_lo_q);
    prod_d = full_d[FRAC_W +: DATA_W];
  end

  assign unused_full_bits = ^{full_d[FRAC_W-1:0], full_d[FULL_W-1:FRAC_W+DATA_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pp_lo_q <= '0;
      pp_hi_q <= '0;
      prod_q  <= '0;
    end else begin
      pp_lo_q <= pp_lo_d;
      pp_hi_q <= pp_hi_d;
      prod_q  <= prod_d;
    end
  end

  assign prod = prod_q;

  // R6: a zero operand yields a zero product two stages later
  a_r6_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(opnd, 2) == '0) |-> (prod == '0));

endmodule

// File: rtl/ilv_acc_stage.sv
// Input register, wrapping adder, result register and the feedback
// register that closes the four-delay loop.
module ilv_acc_stage #(
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic signed [DATA_W-1:0] prod,
  output logic signed [DATA_W-1:0] acc,
  output logic signed [DATA_W-1:0] fb
);

  logic signed [DATA_W-1:0] in_q;
  logic signed [DATA_W-1:0] acc_q, acc_d;
  logic signed [DATA_W-1:0] fb_q;

  always_comb begin
    acc_d = in_q + prod;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      acc_q <= '0;
      fb_q  <= '0;
    end else begin
      in_q  <= in_data;
      acc_q <= acc_d;
      fb_q  <= acc_q;
    end
  end

  assign acc = acc_q;
  assign fb  = fb_q;

endmodule

// File: rtl/ilv_mac_filter.sv
// Top: one pipelined multiply-add shared by two interleaved lag-two
// recursions. Loop: acc -> fb -> partial products -> product -> acc.
module ilv_mac_filter
  import ilv_mac_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] coef_a,
  input  logic [DATA_W-1:0] coef_b,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_tag,
  output logic [DATA_W-1:0] out_data,
  output logic              out_chan,
  output logic              out_valid,
  output logic              out_tag_err
);

  chan_e                    out_ch, fb_ch;
  logic signed [DATA_W-1:0] coef_sel;
  logic signed [DATA_W-1:0] fb_val, prod_val, acc_val;

  ilv_slot_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_tag      (in_tag),
    .out_ch      (out_ch),
    .fb_ch       (fb_ch),
    .out_valid   (out_valid),
    .out_tag_err (out_tag_err)
  );

  // the product formed from fb belongs to the slot four ahead, same parity
  always_comb begin
    coef_sel = (fb_ch == CH_Y) ? $signed(coef_b) : $signed(coef_a);
  end

  ilv_split_mul #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .coef  (coef_sel),
    .opnd  (fb_val),
    .prod  (prod_val)
  );

  ilv_acc_stage #(.DATA_W(DATA_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_data ($signed(in_data)),
    .prod    (prod_val),
    .acc     (acc_val),
    .fb      (fb_val)
  );

  assign out_data = acc_val;
  assign out_chan = 1'(out_ch);

  // cycles since reset, saturating; supports the start-up check
  logic [2:0] since_rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst_q <= '0;
    else if (since_rst_q != 3'd7) since_rst_q <= since_rst_q + 3'd1;
  end

  // R5: first four results equal the inputs two edges back
  a_r5_startup_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q >= 3'd2 && since_rst_q <= 3'd5) |-> (out_data == $past(in_data, 2)));

  // R1/R10: nothing valid in the first two cycles
  a_r10_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst_q < 3'd2) |-> !out_valid);

endmodule

// File: tb/ilv_mac_filter_tb.sv
module ilv_mac_filter_tb;

  logic        clk;
  logic        rst_n;
  logic [23:0] coef_a, coef_b, in_data;
  logic        in_tag;
  logic [23:0] out_data;
  logic        out_chan, out_valid, out_tag_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ilv_mac_filter u_dut (
    .clk(clk), .rst_n(rst_n), .coef_a(coef_a), .coef_b(coef_b),
    .in_data(in_data), .in_tag(in_tag), .out_data(out_data),
    .out_chan(out_chan), .out_valid(out_valid), .out_tag_err(out_tag_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic longint wrap24(longint v);
    logic [23:0] t;
    t = v[23:0];
    return longint'($signed(t));
  endfunction

  function automatic longint mulq(longint c, longint s);
    return wrap24((c * s) >>> 12);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    in_data = '0;
    in_tag  = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", longint'(out_valid), 0);
    chk("R1 data in reset", longint'(out_data), 0);
    chk("R1 err in reset", longint'(out_tag_err), 0);
    rst_n = 1'b1;
  endtask

  // mode 0: directed start then random; 1: full-scale wrap;
  // 2: corrupted tags; 3: one-LSB coefficients for floor behaviour
  task automatic run_seq(int n, int mode, longint ca, longint cb);
    longint stim [0:511];
    longint expd [0:511];
    bit     expe [0:511];
    coef_a = ca[23:0];
    coef_b = cb[23:0];
    do_reset();
    for (int i = 0; i < n + 2; i++) begin
      if (i == 1) chk("R10 valid before first result", longint'(out_valid), 0);
      if (i >= 2) begin
        int j = i - 2;
        string lbl;
        if (j < 4) lbl = "R5 R2";
        else if (mode == 1) lbl = "R6 wrap";
        else if (mode == 3) lbl = "R6 floor";
        else if (mode == 2) lbl = "R9 R2";
        else lbl = (j % 2 == 0) ? "R3 R2" : "R4 R2";
        chk("R10 valid", longint'(out_valid), 1);
        chk(lbl, wrap24(longint'(out_data)), expd[j]);
        chk("R7 chan", longint'(out_chan), longint'(j % 2));
        chk("R8 tag flag", longint'(out_tag_err), longint'(expe[j]));
      end
      if (i < n) begin
        longint v;
        bit     bad;
        case (mode)
          0: begin
            if (i == 0) v = 4096;
            else if (i == 1) v = -8192;
            else if (i == 2) v = 12288;
            else if (i == 3) v = -2048;
            else v = longint'($urandom_range(0, 32767)) - 16384;
          end
          1: v = wrap24(longint'($urandom()));
          default: v = longint'($urandom_range(0, 8191)) - 4096;
        endcase
        bad = (mode == 2) && ($urandom_range(0, 5) == 0);
        stim[i] = v;
        expe[i] = bad;
        expd[i] = wrap24(v + mulq((i % 2 == 0) ? ca : cb, (i >= 4) ? expd[i-4] : 0));
        in_data = v[23:0];
        in_tag  = 1'((i % 2) ^ int'(bad));
      end else begin
        in_data = '0;
        in_tag  = 1'(i % 2);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    coef_a = '0; coef_b = '0; in_data = '0; in_tag = 1'b0;
    run_seq(200, 0, 2048, -3072);   // R3 R4: distinct stable coefficients
    run_seq(120, 1, 4096, 0);       // R6 wrap, channel y pass-through
    run_seq(160, 2, 3500, -1800);   // R8 R9 corrupted tags
    run_seq(60, 3, 1, -1);          // R6 floor toward minus infinity
    run_seq(40, 0, -4095, 4095);    // R3 R4 near-unity magnitudes
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule